// File: doc/BRIEF.md
# Vector Register Attribute Lookup

This unit tells the rest of a vector-capable datapath how an architectural register should be treated. For a queried register number it returns an element width code and an element count. The answer comes from a small ordered table of configuration entries. Each entry names one register and carries the width and the length to use for it. A configuration write port loads one entry per clock.

The table is searched from the lowest entry index upward, and the first valid entry whose register tag equals the query wins. When no entry qualifies, the register is scalar. In that case the length is one, and the width is the default code that the caller supplies with the query, usually derived from the opcode. The query path is purely combinational from the stored table. There is no handshake and no back-pressure on it: the answer is present in the same cycle as the query and follows every change of the query inputs. The write port is a plain strobe that is accepted on every cycle in which it is high.

Top module: `vreg_attr_lookup`

## Requirements
- R1: After reset every entry is invalid, so any query reports a miss.
- R2: On a miss `q_hit` is 0, `q_idx` is 0, `q_len` is 1 and `q_wcode` equals `q_dflt_wcode`.
- R3: When a valid entry's tag equals `q_reg`, `q_hit` is 1 and `q_idx`, `q_wcode` and `q_len` all come from that one entry.
- R4: When two valid entries carry the same tag, the lower index wins: with both matching, `q_idx` is 0 and the attributes are those of entry 0.
- R5: An entry written with `wr_valid` = 0 never matches, even if its tag equals the query.
- R6: A write with `wr_en` = 1 updates entry `wr_idx` at the rising clock edge. A query in the same cycle still sees the contents from before the edge.
- R7: A write changes only the addressed entry. The other entry keeps its contents.
- R8: With `wr_en` = 0, changes on the other write inputs leave the table unchanged.
- R9: Width codes (0 = 8 bit, 1 = 16 bit, 2 = 32 bit, 3 = 64 bit) and the full 8-bit length range, including 0 and 255, are stored and returned exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_idx | input | 1 | Entry index to write |
| wr_tag | input | 5 | Register number to store in the entry |
| wr_wcode | input | 2 | Width code to store |
| wr_len | input | 8 | Vector length to store |
| wr_valid | input | 1 | Valid bit to store |
| q_reg | input | 5 | Register number being looked up |
| q_dflt_wcode | input | 2 | Width code to return on a miss |
| q_wcode | output | 2 | Resulting width code |
| q_len | output | 8 | Resulting vector length |
| q_hit | output | 1 | A valid entry matched |
| q_idx | output | 1 | Index of the winning entry, 0 on a miss |

## Verification
The hardest state to reach from the ports is a query that can see both a pending write and the stored value at once. The stimulus has to hold a write to the very entry that currently answers the query, with different attributes, and compare the outputs just before and just after the edge. A second hard state is two valid entries holding the same tag with different attributes. The bench builds that state and then removes the lower entry's valid bit, so it shows both the priority winner and the fall-through to entry 1.

// File: rtl/vreg_attr_pkg.sv
package vreg_attr_pkg;

  parameter int TAG_W = 5;
  parameter int LEN_W = 8;
  parameter int WC_W  = 2;

  // element width code; numeric values are part of the interface
  typedef enum logic [WC_W-1:0] {
    WC_8  = 2'd0,
    WC_16 = 2'd1,
    WC_32 = 2'd2,
    WC_64 = 2'd3
  } wcode_e;

  typedef struct packed {
    logic             vld;
    logic [TAG_W-1:0] tag;
    wcode_e           wc;
    logic [LEN_W-1:0] len;
  } attr_ent_t;

  localparam logic [LEN_W-1:0] SCALAR_LEN = LEN_W'(1);

endpackage

// File: rtl/vreg_attr_store.sv
module vreg_attr_store
  import vreg_attr_pkg::*;
#(
  parameter int NUM_ENT = 2,
  parameter int IDX_W   = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  attr_ent_t                 wr_ent,
  output attr_ent_t [NUM_ENT-1:0]   ent_q
);

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[e] <= '0;
      end else if (sel) begin
        ent_q[e] <= wr_ent;
      end
    end

    // R7 / R8: an entry not addressed by an enabled write keeps its value
    p_hold_unaddressed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_idx == IDX_W'(e)) |=> $stable(ent_q[e]));
  end

  // R6: the addressed entry holds the written fields after the edge
  p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ent_q[$past(wr_idx)] == $past(wr_ent));

endmodule

// File: rtl/vreg_attr_match.sv
module vreg_attr_match
  import vreg_attr_pkg::*;
#(
  parameter int NUM_ENT = 2
) (
  input  attr_ent_t [NUM_ENT-1:0] ent_q,
  input  logic [TAG_W-1:0]        q_tag,
  output logic [NUM_ENT-1:0]      hit_vec
);

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_cmp
    assign hit_vec[e] = ent_q[e].vld && (ent_q[e].tag == q_tag);
  end

endmodule

// File: rtl/vreg_attr_select.sv
module vreg_attr_select
  import vreg_attr_pkg::*;
#(
  parameter int NUM_ENT = 2,
  parameter int IDX_W   = 1
) (
  input  attr_ent_t [NUM_ENT-1:0] ent_q,
  input  logic [NUM_ENT-1:0]      hit_vec,
  input  wcode_e                  dflt_wc,
  output wcode_e                  sel_wc,
  output logic [LEN_W-1:0]        sel_len,
  output logic                    sel_hit,
  output logic [IDX_W-1:0]        sel_idx
);

  // lowest index wins: scan from the top down so the last assignment
  // is the lowest matching entry
  always_comb begin
    sel_hit = 1'b0;
    sel_idx = '0;
    sel_wc  = dflt_wc;
    sel_len = SCALAR_LEN;
    for (int e = NUM_ENT - 1; e >= 0; e--) begin
      if (hit_vec[e]) begin
        sel_hit = 1'b1;
        sel_idx = IDX_W'(e);
        sel_wc  = ent_q[e].wc;
        sel_len = ent_q[e].len;
      end
    end
  end

endmodule

// File: rtl/vreg_attr_lookup.sv
module vreg_attr_lookup
  import vreg_attr_pkg::*;
#(
  parameter int NUM_ENT = 2,
  localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [WC_W-1:0]  wr_wcode,
  input  logic [LEN_W-1:0] wr_len,
  input  logic             wr_valid,
  input  logic [TAG_W-1:0] q_reg,
  input  logic [WC_W-1:0]  q_dflt_wcode,
  output logic [WC_W-1:0]  q_wcode,
  output logic [LEN_W-1:0] q_len,
  output logic             q_hit,
  output logic [IDX_W-1:0] q_idx
);

  attr_ent_t                 wr_ent;
  attr_ent_t [NUM_ENT-1:0]   ent_q;
  logic      [NUM_ENT-1:0]   hit_vec;
  wcode_e                    sel_wc;

  always_comb begin
    wr_ent.vld = wr_valid;
    wr_ent.tag = wr_tag;
    wr_ent.wc  = wcode_e'(wr_wcode);
    wr_ent.len = wr_len;
  end

  vreg_attr_store #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) store_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_ent (wr_ent),
    .ent_q  (ent_q)
  );

  vreg_attr_match #(.NUM_ENT(NUM_ENT)) match_i (
    .ent_q   (ent_q),
    .q_tag   (q_reg),
    .hit_vec (hit_vec)
  );

  vreg_attr_select #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) select_i (
    .ent_q   (ent_q),
    .hit_vec (hit_vec),
    .dflt_wc (wcode_e'(q_dflt_wcode)),
    .sel_wc  (sel_wc),
    .sel_len (q_len),
    .sel_hit (q_hit),
    .sel_idx (q_idx)
  );

  assign q_wcode = WC_W'(sel_wc);

  // R3: a reported hit names a valid entry tagged with the query, and
  // the attributes come from that same entry
  p_hit_from_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    q_hit |-> (ent_q[q_idx].vld && ent_q[q_idx].tag == q_reg &&
               q_len == ent_q[q_idx].len && q_wcode == WC_W'(ent_q[q_idx].wc)));

  // R2: a miss returns the scalar length and the caller's default width
  p_miss_scalar_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !q_hit |-> (q_len == SCALAR_LEN && q_wcode == q_dflt_wcode && q_idx == '0));

  // R4: entry 0 matching always wins
  p_low_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_vec[0] |-> (q_hit && q_idx == '0));

  // R5: an invalid entry never contributes a match
  for (genvar e = 0; e < NUM_ENT; e++) begin : g_chk
    p_invalid_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !ent_q[e].vld |-> !hit_vec[e]);
  end

  // R1: the first cycle after reset release reports a miss
  p_reset_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !q_hit);

endmodule

// File: tb/vreg_attr_lookup_tb_top.sv
module vreg_attr_lookup_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [0:0] wr_idx = '0;
  logic [4:0] wr_tag = '0;
  logic [1:0] wr_wcode = '0;
  logic [7:0] wr_len = '0;
  logic       wr_valid = 1'b0;
  logic [4:0] q_reg = '0;
  logic [1:0] q_dflt_wcode = '0;
  logic [1:0] q_wcode;
  logic [7:0] q_len;
  logic       q_hit;
  logic [0:0] q_idx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 4 ns period

  vreg_attr_lookup dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_wcode(wr_wcode),
    .wr_len(wr_len), .wr_valid(wr_valid),
    .q_reg(q_reg), .q_dflt_wcode(q_dflt_wcode),
    .q_wcode(q_wcode), .q_len(q_len), .q_hit(q_hit), .q_idx(q_idx)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  // apply a query between edges and compare all outputs
  task automatic query(input string req, input int r, input int dflt,
                       input int hit, input int idx, input int wc, input int len);
    @(negedge clk);
    q_reg = 5'(r);
    q_dflt_wcode = 2'(dflt);
    #1;
    chk(req, "hit", int'(q_hit), hit);
    chk(req, "idx", int'(q_idx), idx);
    chk(req, "wcode", int'(q_wcode), wc);
    chk(req, "len", int'(q_len), len);
  endtask

  task automatic write_ent(input int idx, input int tag, input int wc,
                           input int len, input int vld);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 1'(idx); wr_tag = 5'(tag);
    wr_wcode = 2'(wc); wr_len = 8'(len); wr_valid = vld[0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    query("R1", 0, 2, 0, 0, 2, 1);
    query("R1", 31, 1, 0, 0, 1, 1);
  endtask

  task automatic t_miss;
    for (int d = 0; d < 4; d++) query("R2", 3 + d, d, 0, 0, d, 1);
  endtask

  task automatic t_hits;
    write_ent(0, 7, 3, 200, 1);
    query("R3", 7, 0, 1, 0, 3, 200);
    write_ent(1, 31, 1, 0, 1);
    query("R9", 31, 2, 1, 1, 1, 0);
    write_ent(1, 31, 0, 255, 1);
    query("R9", 31, 3, 1, 1, 0, 255);
    query("R2", 8, 2, 0, 0, 2, 1);
  endtask

  task automatic t_priority;
    write_ent(0, 9, 0, 5, 1);
    write_ent(1, 9, 2, 6, 1);
    query("R4", 9, 3, 1, 0, 0, 5);
    write_ent(0, 9, 0, 5, 0);
    query("R5", 9, 3, 1, 1, 2, 6);
    write_ent(1, 12, 3, 44, 0);
    query("R5", 12, 1, 0, 0, 1, 1);
  endtask

  task automatic t_same_cycle;
    write_ent(0, 20, 1, 17, 1);
    @(negedge clk);
    q_reg = 5'd20; q_dflt_wcode = 2'd0;
    wr_en = 1'b1; wr_idx = 1'b0; wr_tag = 5'd20; wr_wcode = 2'd2;
    wr_len = 8'd90; wr_valid = 1'b1;
    #1;
    chk("R6", "old len before edge", int'(q_len), 17);
    chk("R6", "old wcode before edge", int'(q_wcode), 1);
    @(posedge clk);
    #1;
    chk("R6", "new len after edge", int'(q_len), 90);
    chk("R6", "new wcode after edge", int'(q_wcode), 2);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_isolation;
    write_ent(1, 21, 3, 33, 1);
    query("R7", 20, 0, 1, 0, 2, 90);
    query("R7", 21, 0, 1, 1, 3, 33);
    @(negedge clk);
    wr_en = 1'b0; wr_idx = 1'b0; wr_tag = 5'd21; wr_wcode = 2'd0;
    wr_len = 8'd1; wr_valid = 1'b1;
    @(negedge clk);
    wr_idx = 1'b1; wr_tag = 5'd2;
    @(negedge clk);
    query("R8", 20, 0, 1, 0, 2, 90);
    query("R8", 21, 0, 1, 1, 3, 33);
    query("R8", 2, 1, 0, 0, 1, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_miss();
    t_hits();
    t_priority();
    t_same_cycle();
    t_isolation();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule